// File: doc/BRIEF.md
# Program Counter with Return Stack

This block keeps the fetch address of a small microcontroller core with 14-bit instructions, together with an eight-level return-address stack that only the hardware reaches. On every cycle with the step enable high it applies one command: advance to the next word, jump, call, one of three return flavours, enter an interrupt, or hold. Jump and call targets carry only 11 bits; the two upper address bits come from a page-select input, so program space is reached in 2K-word pages starting at 0000h, 0800h, 1000h and 1800h.

The address is 13 bits wide. A parameter gives the number of implemented words (4K or 8K). Any address that lands above that range folds back into it, and incrementing from the last implemented word returns to 0000h. Reset puts the fetch address at 0000h. Interrupt entry saves the current address on the stack and goes to 0004h. The stack is a circular buffer: a ninth push overwrites the oldest entry, and a pop with nothing stored still reads the slot below the pointer. Neither case is an error, but each one raises a one-cycle debug pulse. A return from interrupt also raises a one-cycle pulse that re-enables interrupts globally.

Top module: `pc_stack_unit`

## Requirements
- R1: While reset is held and at its release, fetch_addr is 0000h, stk_empty is 1, stk_full is 0, all three pulse outputs are 0, and every stack slot holds 0000h.
- R2: Command code 0 (next) loads fetch_addr+1; from the highest implemented address (IMPL_WORDS-1) it goes to 0000h.
- R3: Command code 1 (jump) loads {page_sel, target}, with page_sel as bits 12:11 and target as bits 10:0. The result is reduced modulo IMPL_WORDS.
- R4: Command code 2 (call) pushes (fetch_addr+1) modulo IMPL_WORDS and loads the same address a jump would.
- R5: Command codes 3 (return), 4 (return from interrupt) and 5 (return with literal) each load the most recently pushed address and pop it, in last-in first-out order.
- R6: gie_set_pulse is 1 for exactly the one cycle after a step with code 4, and is 0 after every other step and after idle cycles.
- R7: Command code 6 (interrupt) pushes the current fetch_addr unchanged and loads 0004h.
- R8: With step_en low, whatever the command, or with code 7 (hold), fetch_addr, the stack contents and the flags stay unchanged.
- R9: The stack holds 8 entries and stk_full is 1 when all 8 are in use. A push while full overwrites the oldest entry, leaves stk_full at 1, and sets stk_ovf_pulse for one cycle.
- R10: A pop while empty reads the slot just below the circular write pointer, leaves stk_empty at 1, and sets stk_unf_pulse for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Apply cmd on this edge |
| cmd | input | 3 | Command code (0 next … 7 hold) |
| target | input | 11 | Jump or call target within the page |
| page_sel | input | 2 | Upper address bits for jump and call |
| fetch_addr | output | 13 | Current program counter |
| stk_empty | output | 1 | No entries stored |
| stk_full | output | 1 | Eight entries stored |
| stk_ovf_pulse | output | 1 | One-cycle pulse after a push onto a full stack |
| stk_unf_pulse | output | 1 | One-cycle pulse after a pop from an empty stack |
| gie_set_pulse | output | 1 | One-cycle pulse after a return from interrupt |

## Verification
The assertions assume a command is valid whenever step_en is high, and that target and page_sel are stable only in those cycles. When step_en is low, cmd may hold any value. The bench drives inputs only at falling edges and lowers step_en between steps. During idle stretches it puts arbitrary codes on cmd to show they have no effect. The configuration under test implements 4K words, so that folding is reachable. The stimulus pushes the stack past eight levels and pops it below zero on purpose, because both cases are defined behaviour here and not illegal input.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
  typedef enum logic [2:0] {
    CMD_NEXT  = 3'd0,
    CMD_JUMP  = 3'd1,
    CMD_CALL  = 3'd2,
    CMD_RET   = 3'd3,
    CMD_RETI  = 3'd4,
    CMD_RETLW = 3'd5,
    CMD_INTR  = 3'd6,
    CMD_HOLD  = 3'd7
  } pcs_cmd_e;
endpackage

// File: rtl/pcs_seq_ctrl.sv
`timescale 1ns/1ps
module pcs_seq_ctrl
  import pcs_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int LIT_W      = 11,
  parameter int IMPL_WORDS = 8192,
  parameter int INT_VEC    = 4
) (
  input  logic                  step_en,
  input  pcs_cmd_e              cmd_e,
  input  logic [PC_W-1:0]       pc_q,
  input  logic [LIT_W-1:0]      target,
  input  logic [PC_W-LIT_W-1:0] page_sel,
  input  logic [PC_W-1:0]       stack_top,
  output logic [PC_W-1:0]       pc_nxt,
  output logic                  ev_push,
  output logic                  ev_pop,
  output logic [PC_W-1:0]       push_val,
  output logic                  ev_reti
);
  localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(IMPL_WORDS - 1);
  localparam logic [PC_W-1:0] INT_ADDR  = PC_W'(INT_VEC);

  // Fold any address into the implemented space (power-of-two size)
  function automatic logic [PC_W-1:0] fold(input logic [PC_W-1:0] a);
    return a & ADDR_MASK;
  endfunction

  function automatic logic [PC_W-1:0] seq_inc(input logic [PC_W-1:0] a);
    return fold(a + PC_W'(1));
  endfunction

  function automatic logic [PC_W-1:0] paged(input logic [PC_W-LIT_W-1:0] pg,
                                            input logic [LIT_W-1:0] lit);
    return fold({pg, lit});
  endfunction

  always_comb begin
    pc_nxt   = pc_q;
    ev_push  = 1'b0;
    ev_pop   = 1'b0;
    push_val = seq_inc(pc_q);
    ev_reti  = 1'b0;
    if (step_en) begin
      unique case (cmd_e)
        CMD_NEXT: pc_nxt = seq_inc(pc_q);
        CMD_JUMP: pc_nxt = paged(page_sel, target);
        CMD_CALL: begin
          pc_nxt   = paged(page_sel, target);
          ev_push  = 1'b1;
          push_val = seq_inc(pc_q);
        end
        CMD_RET, CMD_RETLW: begin
          pc_nxt = stack_top;
          ev_pop = 1'b1;
        end
        CMD_RETI: begin
          pc_nxt  = stack_top;
          ev_pop  = 1'b1;
          ev_reti = 1'b1;
        end
        CMD_INTR: begin
          pc_nxt   = INT_ADDR;
          ev_push  = 1'b1;
          push_val = pc_q;
        end
        CMD_HOLD: pc_nxt = pc_q;
        default:  pc_nxt = pc_q;
      endcase
    end
  end
endmodule

// File: rtl/pcs_ret_stack.sv
`timescale 1ns/1ps
module pcs_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val,
  output logic         empty,
  output logic         full,
  output logic         ovf_pulse,
  output logic         unf_pulse
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  // Slot read by a pop: the one just below the circular write pointer
  assign rd_ptr  = wr_ptr_q - PTR_W'(1);
  assign top_val = slot_q[rd_ptr];
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          slot_q[g] <= '0;
        else if (push && (wr_ptr_q == PTR_W'(g)))
          slot_q[g] <= push_val;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= '0;
      cnt_q     <= '0;
      ovf_pulse <= 1'b0;
      unf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= push && full;
      unf_pulse <= pop && empty;
      if (push) begin
        wr_ptr_q <= wr_ptr_q + PTR_W'(1);
        if (!full) cnt_q <= cnt_q + CNT_W'(1);
      end else if (pop) begin
        wr_ptr_q <= rd_ptr;
        if (!empty) cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pc_stack_unit.sv
`timescale 1ns/1ps
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int LIT_W      = 11,
  parameter int DEPTH      = 8,
  parameter int IMPL_WORDS = 8192,
  parameter int INT_VEC    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_en,
  input  logic [2:0]            cmd,
  input  logic [LIT_W-1:0]      target,
  input  logic [PC_W-LIT_W-1:0] page_sel,
  output logic [PC_W-1:0]       fetch_addr,
  output logic                  stk_empty,
  output logic                  stk_full,
  output logic                  stk_ovf_pulse,
  output logic                  stk_unf_pulse,
  output logic                  gie_set_pulse
);
  pcs_cmd_e        cmd_e;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] stack_top;
  logic [PC_W-1:0] push_val;
  logic            ev_push;
  logic            ev_pop;
  logic            ev_reti;

  assign cmd_e = pcs_cmd_e'(cmd);

  pcs_seq_ctrl #(
    .PC_W(PC_W), .LIT_W(LIT_W), .IMPL_WORDS(IMPL_WORDS), .INT_VEC(INT_VEC)
  ) i_ctrl (
    .step_en  (step_en),
    .cmd_e    (cmd_e),
    .pc_q     (pc_q),
    .target   (target),
    .page_sel (page_sel),
    .stack_top(stack_top),
    .pc_nxt   (pc_nxt),
    .ev_push  (ev_push),
    .ev_pop   (ev_pop),
    .push_val (push_val),
    .ev_reti  (ev_reti)
  );

  pcs_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) i_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ev_push),
    .pop      (ev_pop),
    .push_val (push_val),
    .top_val  (stack_top),
    .empty    (stk_empty),
    .full     (stk_full),
    .ovf_pulse(stk_ovf_pulse),
    .unf_pulse(stk_unf_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q          <= '0;
      gie_set_pulse <= 1'b0;
    end else begin
      pc_q          <= pc_nxt;
      gie_set_pulse <= ev_reti;
    end
  end

  assign fetch_addr = pc_q;
endmodule

// File: rtl/pcs_checker.sv
`timescale 1ns/1ps
module pcs_checker
  import pcs_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int LIT_W      = 11,
  parameter int IMPL_WORDS = 8192,
  parameter int INT_VEC    = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  step_en,
  input logic [2:0]            cmd,
  input logic [LIT_W-1:0]      target,
  input logic [PC_W-LIT_W-1:0] page_sel,
  input logic [PC_W-1:0]       fetch_addr,
  input logic                  stk_empty,
  input logic                  stk_full,
  input logic                  stk_ovf_pulse,
  input logic                  stk_unf_pulse,
  input logic                  gie_set_pulse
);
  localparam logic [PC_W-1:0] MASK = PC_W'(IMPL_WORDS - 1);

  AST_NEXT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cmd == CMD_NEXT) |=> fetch_addr == ((PC_W'($past(fetch_addr) + PC_W'(1))) & MASK)); // R2
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cmd == CMD_JUMP) |=> fetch_addr == ($past({page_sel, target}) & MASK)); // R3
  AST_CALL_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cmd == CMD_CALL) |=> !stk_empty); // R4
  AST_GIE_ON_RETI: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cmd == CMD_RETI) |=> gie_set_pulse); // R6
  AST_GIE_ONLY_RETI: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en && cmd == CMD_RETI) |=> !gie_set_pulse); // R6
  AST_INT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cmd == CMD_INTR) |=> fetch_addr == PC_W'(INT_VEC)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(fetch_addr) && $stable(stk_empty) && $stable(stk_full))); // R8
  AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf_pulse |-> stk_full); // R9
  AST_UNF_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf_pulse |-> stk_empty); // R10
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_empty && stk_full)); // R9
endmodule

bind pc_stack_unit pcs_checker #(
  .PC_W(PC_W), .LIT_W(LIT_W), .IMPL_WORDS(IMPL_WORDS), .INT_VEC(INT_VEC)
) i_pcs_checker (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .cmd(cmd), .target(target),
  .page_sel(page_sel), .fetch_addr(fetch_addr), .stk_empty(stk_empty),
  .stk_full(stk_full), .stk_ovf_pulse(stk_ovf_pulse),
  .stk_unf_pulse(stk_unf_pulse), .gie_set_pulse(gie_set_pulse)
);

// File: tb/test_pc_stack_unit.sv
`timescale 1ns/1ps
module test_pc_stack_unit;
  localparam int IMPL = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [10:0] target_i = '0;
  logic [1:0]  page_i = '0;
  logic [12:0] fetch_addr;
  logic        stk_empty, stk_full, ovf_p, unf_p, gie_p;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference model state
  int pc_m = 0;
  int stk_m [8];
  int ptr_m = 0;
  int cnt_m = 0;

  always #2.5 clk = ~clk;

  pc_stack_unit #(.IMPL_WORDS(IMPL)) i_pc_stack_unit (
    .clk(clk), .rst_n(rst_n), .step_en(step_i), .cmd(cmd_i), .target(target_i),
    .page_sel(page_i), .fetch_addr(fetch_addr), .stk_empty(stk_empty),
    .stk_full(stk_full), .stk_ovf_pulse(ovf_p), .stk_unf_pulse(unf_p),
    .gie_set_pulse(gie_p)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_flags(input bit ovf_e, input bit unf_e, input bit gie_e);
    chk("R9 stk_full", int'(stk_full), int'(cnt_m == 8));
    chk("R10 stk_empty", int'(stk_empty), int'(cnt_m == 0));
    chk("R9 stk_ovf_pulse", int'(ovf_p), int'(ovf_e));
    chk("R10 stk_unf_pulse", int'(unf_p), int'(unf_e));
    chk("R6 gie_set_pulse", int'(gie_p), int'(gie_e));
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs checked
  task automatic step(input int c, input int t, input int p);
    int  jt;
    bit  ovf_e = 0, unf_e = 0, gie_e = 0;
    string tag;
    cmd_i = 3'(c); target_i = 11'(t); page_i = 2'(p); step_i = 1'b1;
    jt = (p * 2048 + t) % IMPL;
    case (c)
      0: begin tag = "R2 next"; pc_m = (pc_m + 1) % IMPL; end
      1: begin tag = "R3 jump"; pc_m = jt; end
      2: begin
        tag = "R4 call";
        if (cnt_m == 8) ovf_e = 1; else cnt_m++;
        stk_m[ptr_m] = (pc_m + 1) % IMPL; ptr_m = (ptr_m + 1) % 8;
        pc_m = jt;
      end
      3, 4, 5: begin
        tag = "R5 return";
        if (cnt_m == 0) unf_e = 1; else cnt_m--;
        ptr_m = (ptr_m + 7) % 8; pc_m = stk_m[ptr_m];
        if (c == 4) gie_e = 1;
      end
      6: begin
        tag = "R7 interrupt";
        if (cnt_m == 8) ovf_e = 1; else cnt_m++;
        stk_m[ptr_m] = pc_m; ptr_m = (ptr_m + 1) % 8;
        pc_m = 4;
      end
      default: tag = "R8 hold";
    endcase
    @(negedge clk);
    step_i = 1'b0;
    chk(tag, int'(fetch_addr), pc_m);
    check_flags(ovf_e, unf_e, gie_e);
  endtask

  // Idle cycle with a junk command: nothing may move (R8), pulses clear (R6)
  task automatic idle(input int junk);
    cmd_i = 3'(junk); target_i = 11'(junk * 37); page_i = 2'(junk);
    @(negedge clk);
    chk("R8 idle fetch_addr", int'(fetch_addr), pc_m);
    check_flags(0, 0, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) stk_m[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset fetch_addr", int'(fetch_addr), 0);
    chk("R1 reset empty", int'(stk_empty), 1);
    chk("R1 reset full", int'(stk_full), 0);
    chk("R1 reset pulses", int'({ovf_p, unf_p, gie_p}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(fetch_addr), 0);

    // R2: sweep through the full implemented space and past the wrap
    for (int i = 0; i < IMPL + 3; i++) step(0, 0, 0);

    // R3: all pages, spread of targets (pages 2 and 3 fold in the 4K build)
    for (int pg = 0; pg < 4; pg++)
      for (int t = 0; t < 2048; t += 89) step(1, t, pg);
    step(1, 2047, 3);
    step(0, 0, 0);

    // R8: idle with junk commands, then explicit hold code
    for (int j = 0; j < 8; j++) idle(j);
    step(7, 5, 1);

    // R4 R5 R9 R10: nesting from 1 to 11 deep, returns rotate through codes 3,4,5
    for (int d = 1; d <= 11; d++) begin
      step(1, d * 13, d % 4);
      for (int k = 0; k < d; k++) step(2, 100 + k * 7 + d, k % 4);
      for (int k = 0; k < d + 1; k++) begin
        step(3 + (k % 3), 0, 0);
        if (k % 4 == 0) idle(k);
      end
    end

    // R7 R6: interrupt entry and return from interrupt, also nested under calls
    step(1, 321, 1);
    step(6, 0, 0);
    step(0, 0, 0);
    step(4, 0, 0);
    idle(4);
    step(2, 55, 0);
    step(2, 66, 1);
    step(6, 0, 0);
    step(6, 0, 0);
    step(4, 0, 0);
    step(4, 0, 0);
    step(5, 0, 0);
    step(3, 0, 0);
    idle(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule